// File: doc/BRIEF.md
# ADC conversion control sequencer

This block is the control side of a sigma-delta style converter. Software programs one 16-bit configuration word over a simple serial shift interface. The block decodes that word into power, start, repeat, polarity, output format, reference, gain, rate and mode fields. It then runs the converter through either one conversion or an endless chain of conversions.

A behavioural filter stub stands in for the real modulator and filter. It takes a signed sample from the `sample_in` port and turns it into one result at the end of each conversion cycle. Before a result is kept, the stub applies polarity swap, gain and output format. The cycle length comes from the rate field.

After any start, the filter needs four full conversion cycles to settle before the first result is valid. The start bit stays readable as 1 until that first result arrives. A second, independent start strobe lets another register launch a conversion with settings written earlier.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset `cfg_word` reads 0. A frame is 16 `ser_shift` pulses while `ser_sel` is high, MSB first. On the 16th pulse the word is loaded. Bit 15 power-on, bit 14 start, bit 13 bipolar format, bit 12 polarity swap, bit 11 continuous, bit 10 reference select, bits 9:8 gain, bits 7:5 rate, bits 4:2 mode. Bits 1:0 read back as 0. Dropping `ser_sel` discards a partial frame.
- R2: A conversion starts on the clock edge of the 16th shift when the word has bits 15 and 14 set, or on any edge with `mux_start` high while power-on is set. A start during a conversion discards all progress and begins again.
- R3: A conversion cycle lasts 4·2^rate clocks. The first result is registered exactly 16·2^rate clocks after the start edge. Bit 14 of `cfg_word` reads 1 from the start edge until that result.
- R4: With the continuous bit clear at the start, exactly one result is produced and `busy` then falls.
- R5: With the continuous bit set at the start, a new result follows every conversion cycle after the first. `busy` stays high.
- R6: A frame that clears the continuous bit during a continuous run stops the run at once. `adc_data` keeps the last complete result.
- R7: Setting the continuous bit while idle starts nothing.
- R8: A frame with bit 14 clear changes the stored fields but not a conversion in progress. Rate, gain, polarity, format, reference (`act_ref_sel`) and mode (`act_mode`) are captured only at a start.
- R9: With bit 13 set the result is two's complement. With it clear, negative values give 0 and positive values are doubled as unsigned binary.
- R10: With bit 12 set the sample is negated before scaling. Negating -32768 saturates to 32767.
- R11: Gain codes 0, 1, 2, 3 multiply by 1, 2, 4, 8, and the product saturates to the signed 16-bit range.
- R12: A frame with bit 15 clear stops any conversion at once and clears bit 14. `adc_data` is held.
- R13: `data_ready` sets with each result. It clears on `data_rd` if no result arrives in the same cycle; a new result takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel | input | 1 | Frame select for the serial interface |
| ser_shift | input | 1 | One-cycle strobe marking a serial clock rising edge |
| ser_bit | input | 1 | Serial data bit, MSB first |
| mux_start | input | 1 | Alternate start strobe |
| data_rd | input | 1 | Result read strobe |
| sample_in | input | 16 | Signed sample fed to the filter stub |
| cfg_word | output | 16 | Configuration readback with live start bit |
| busy | output | 1 | Conversion sequence active |
| adc_data | output | 16 | Latest result |
| data_ready | output | 1 | Result ready flag |
| act_ref_sel | output | 1 | Reference select captured at the last start |
| act_mode | output | 3 | Mode captured at the last start |

## Verification
The assertions assume that `ser_shift` and `mux_start` are the only inputs that can wake an idle sequencer. They also assume that `data_rd` arriving while idle cannot coincide with a result. Both hold because results need an active sequence.

The stimulus keeps `mux_start` and serial frames apart in time, so an alternate start never lands on a frame's last shift. It holds `sample_in` steady around every result boundary that a directed check looks at.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int WORD_W   = 16;
  localparam int RATE_W   = 3;
  localparam int GAIN_W   = 2;
  localparam int MODE_W   = 3;

  localparam int B_PWR    = 15;
  localparam int B_START  = 14;
  localparam int B_BIP    = 13;
  localparam int B_POL    = 12;
  localparam int B_CONT   = 11;
  localparam int B_REF    = 10;
  localparam int B_GAIN   = 8;
  localparam int B_RATE   = 5;
  localparam int B_MODE   = 2;

  typedef struct packed {
    logic              adce;
    logic              bip;
    logic              pol;
    logic              cont;
    logic              ref_sel;
    logic [GAIN_W-1:0] gain;
    logic [RATE_W-1:0] rate;
    logic [MODE_W-1:0] mode;
  } cfg_t;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETTLE = 2'd1,
    SQ_RUN    = 2'd2
  } sq_state_e;

  function automatic cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
    cfg_t c;
    c.adce    = w[B_PWR];
    c.bip     = w[B_BIP];
    c.pol     = w[B_POL];
    c.cont    = w[B_CONT];
    c.ref_sel = w[B_REF];
    c.gain    = w[B_GAIN +: GAIN_W];
    c.rate    = w[B_RATE +: RATE_W];
    c.mode    = w[B_MODE +: MODE_W];
    return c;
  endfunction

endpackage

// File: rtl/adc_seq_shift.sv
module adc_seq_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_sel,
  input  logic              ser_shift,
  input  logic              ser_bit,
  output logic              frame_done,
  output logic [WORD_W-1:0] word
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-2:0] sreg_q, sreg_d;
  logic [CNT_W-1:0]  bcnt_q, bcnt_d;
  logic              shift_en;

  assign shift_en   = ser_sel & ser_shift;
  assign frame_done = shift_en & (bcnt_q == LAST);
  assign word       = {sreg_q, ser_bit};

  always_comb begin
    sreg_d = sreg_q;
    bcnt_d = bcnt_q;
    if (!ser_sel) begin
      bcnt_d = '0;
    end else if (shift_en) begin
      sreg_d = {sreg_q[WORD_W-3:0], ser_bit};
      bcnt_d = (bcnt_q == LAST) ? '0 : bcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      bcnt_q <= '0;
    end else begin
      if (shift_en) sreg_q <= sreg_d;
      bcnt_q <= bcnt_d;
    end
  end

endmodule

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [WORD_W-1:0] word,
  output cfg_t              cfg_q,
  output cfg_t              cfg_eff,
  output logic              strt_req
);

  cfg_t cfg_d;
  logic unused_dc;

  assign unused_dc = ^word[B_MODE-1:0];
  assign strt_req  = frame_done & word[B_START];

  always_comb begin
    cfg_d = cfg_q;
    if (frame_done) cfg_d = word_to_cfg(word);
  end

  assign cfg_eff = cfg_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (frame_done) begin
      cfg_q <= cfg_d;
    end
  end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  parameter int BASE_LOG2  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  cfg_t cfg_eff,
  input  logic strt_req,
  input  logic mux_start,
  input  logic frame_done,
  output logic busy,
  output logic settling,
  output logic res_stb,
  output cfg_t act_q
);

  localparam int RATE_MAX = (1 << RATE_W) - 1;
  localparam int PER_W    = BASE_LOG2 + RATE_MAX;
  localparam int SET_W    = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [SET_W-1:0] SET_INIT = SET_W'(SETTLE_CYC - 1);

  sq_state_e        st_q, st_d;
  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [SET_W-1:0] stl_q, stl_d;
  cfg_t             act_d;
  logic             go, stop_pwr, stop_cont;

  function automatic logic [PER_W-1:0] period_m1(input logic [RATE_W-1:0] r);
    logic [PER_W:0] full;
    full = ({{PER_W{1'b0}}, 1'b1} << (BASE_LOG2 + int'(r)));
    return PER_W'(full - 1'b1);
  endfunction

  assign go        = cfg_eff.adce & (strt_req | mux_start);
  assign stop_pwr  = ~cfg_eff.adce;
  assign stop_cont = (st_q != SQ_IDLE) & act_q.cont & frame_done & ~cfg_eff.cont;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    stl_d   = stl_q;
    act_d   = act_q;
    res_stb = 1'b0;
    if (stop_pwr) begin
      st_d = SQ_IDLE;
    end else if (go) begin
      st_d  = SQ_SETTLE;
      act_d = cfg_eff;
      cnt_d = period_m1(cfg_eff.rate);
      stl_d = SET_INIT;
    end else if (stop_cont) begin
      st_d = SQ_IDLE;
    end else if (st_q != SQ_IDLE) begin
      if (cnt_q == '0) begin
        cnt_d = period_m1(act_q.rate);
        if (st_q == SQ_SETTLE && stl_q != '0) begin
          stl_d = stl_q - 1'b1;
        end else begin
          res_stb = 1'b1;
          st_d    = act_q.cont ? SQ_RUN : SQ_IDLE;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      stl_q <= '0;
      act_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      stl_q <= stl_d;
      if (go) act_q <= act_d;
    end
  end

  assign busy     = (st_q != SQ_IDLE);
  assign settling = (st_q == SQ_SETTLE);

endmodule

// File: rtl/adc_seq_stub.sv
module adc_seq_stub #(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_stb,
  input  logic              data_rd,
  input  logic [DATA_W-1:0] sample_in,
  input  logic              act_pol,
  input  logic              act_bip,
  input  logic [GAIN_W-1:0] act_gain,
  output logic [DATA_W-1:0] data_q,
  output logic              ready_q
);

  localparam int HEAD  = (1 << GAIN_W) + 1;
  localparam int EXT_W = DATA_W + HEAD;
  localparam logic signed [EXT_W-1:0] MAX_V = EXT_W'((64'sd1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [EXT_W-1:0] MIN_V = -MAX_V - 1;

  logic signed [EXT_W-1:0] ext, flipped, scaled, sat;
  logic [DATA_W-1:0]       result, data_d;
  logic                    ready_d;
  logic                    unused_hi;

  always_comb begin
    ext     = {{HEAD{sample_in[DATA_W-1]}}, sample_in};
    flipped = act_pol ? -ext : ext;
    scaled  = flipped <<< act_gain;
    if (scaled > MAX_V)      sat = MAX_V;
    else if (scaled < MIN_V) sat = MIN_V;
    else                     sat = scaled;
    if (act_bip)             result = sat[DATA_W-1:0];
    else if (sat[EXT_W-1])   result = '0;
    else                     result = {sat[DATA_W-2:0], 1'b0};
  end

  assign unused_hi = ^sat[EXT_W-2:DATA_W];

  always_comb begin
    data_d  = data_q;
    ready_d = ready_q;
    if (res_stb) begin
      data_d  = result;
      ready_d = 1'b1;
    end else if (data_rd) begin
      ready_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      if (res_stb) data_q <= data_d;
      ready_q <= ready_d;
    end
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int SETTLE_CYC = 4,
  parameter int BASE_LOG2  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_sel,
  input  logic              ser_shift,
  input  logic              ser_bit,
  input  logic              mux_start,
  input  logic              data_rd,
  input  logic [DATA_W-1:0] sample_in,
  output logic [WORD_W-1:0] cfg_word,
  output logic              busy,
  output logic [DATA_W-1:0] adc_data,
  output logic              data_ready,
  output logic              act_ref_sel,
  output logic [MODE_W-1:0] act_mode
);

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              frame_done, strt_req, settling, res_stb;
  logic [WORD_W-1:0] word;
  cfg_t              cfg_q, cfg_eff, act;
  logic              unused_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  adc_seq_shift #(.WORD_W(WORD_W)) i_shift (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ser_sel    (ser_sel),
    .ser_shift  (ser_shift),
    .ser_bit    (ser_bit),
    .frame_done (frame_done),
    .word       (word)
  );

  adc_seq_cfg i_cfg (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .frame_done (frame_done),
    .word       (word),
    .cfg_q      (cfg_q),
    .cfg_eff    (cfg_eff),
    .strt_req   (strt_req)
  );

  adc_seq_fsm #(.SETTLE_CYC(SETTLE_CYC), .BASE_LOG2(BASE_LOG2)) i_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cfg_eff    (cfg_eff),
    .strt_req   (strt_req),
    .mux_start  (mux_start),
    .frame_done (frame_done),
    .busy       (busy),
    .settling   (settling),
    .res_stb    (res_stb),
    .act_q      (act)
  );

  adc_seq_stub #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) i_stub (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .res_stb    (res_stb),
    .data_rd    (data_rd),
    .sample_in  (sample_in),
    .act_pol    (act.pol),
    .act_bip    (act.bip),
    .act_gain   (act.gain),
    .data_q     (adc_data),
    .ready_q    (data_ready)
  );

  assign unused_act  = ^{act.adce, act.cont, act.rate};
  assign act_ref_sel = act.ref_sel;
  assign act_mode    = act.mode;

  assign cfg_word = {cfg_q.adce, settling, cfg_q.bip, cfg_q.pol, cfg_q.cont,
                     cfg_q.ref_sel, cfg_q.gain, cfg_q.rate, cfg_q.mode,
                     {B_MODE{1'b0}}};

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ser_shift,
  input logic        mux_start,
  input logic        data_rd,
  input logic        busy,
  input logic        data_ready,
  input logic [15:0] adc_data,
  input logic [15:0] cfg_word
);

  // R4: a result flag can only rise out of an active sequence
  a_r4_ready_from_active: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> $past(busy));

  // R6: an idle sequencer never changes the held result
  a_r6_data_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(adc_data));

  // R7: idle stays idle without a shift or an alternate start
  a_r7_no_self_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !mux_start && !ser_shift) |=> !busy);

  // R12: powered-down configuration never coexists with activity
  a_r12_pwr_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_word[15] |-> !busy);

  // R13: a read while idle always clears the flag
  a_r13_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !busy) |=> !data_ready);

endmodule

bind adc_seq_ctrl adc_seq_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ser_shift  (ser_shift),
  .mux_start  (mux_start),
  .data_rd    (data_rd),
  .busy       (busy),
  .data_ready (data_ready),
  .adc_data   (adc_data),
  .cfg_word   (cfg_word)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               ser_sel = 1'b0, ser_shift = 1'b0, ser_bit = 1'b0;
  logic               mux_start = 1'b0, data_rd = 1'b0;
  logic signed [15:0] sample_in = '0;
  logic [15:0]        cfg_word, adc_data;
  logic               busy, data_ready, act_ref_sel;
  logic [2:0]         act_mode;

  int n_chk = 0, n_err = 0;
  bit cmp_on = 0, done = 0;

  always #2.5 clk = ~clk;

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .ser_sel(ser_sel), .ser_shift(ser_shift),
    .ser_bit(ser_bit), .mux_start(mux_start), .data_rd(data_rd),
    .sample_in(sample_in), .cfg_word(cfg_word), .busy(busy),
    .adc_data(adc_data), .data_ready(data_ready),
    .act_ref_sel(act_ref_sel), .act_mode(act_mode)
  );

  // ---------------- behavioural reference model ----------------
  int          m_cnt, m_gain, m_rate, m_mode, a_gain, a_rate, a_mode, m_rem, m_data;
  logic [15:0] m_sh;
  bit m_adce, m_bip, m_pol, m_cont, m_ref, m_busy, m_pend, m_rdy;
  bit a_cont, a_pol, a_bip, a_ref, fd, go, res;

  function automatic int fmt(int s, bit pol, int g, bit bip);
    int v;
    v = pol ? -s : s;
    v = v * (1 << g);
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    if (bip) return v & 16'hFFFF;
    return (v < 0) ? 0 : v * 2;
  endfunction

  function automatic logic [15:0] mk(bit pw, bit st, bit bp, bit pl, bit ct,
                                     bit rf, int g, int r, int md);
    return {pw, st, bp, pl, ct, rf, 2'(g), 3'(r), 3'(md), 2'b00};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_sh = '0; m_adce = 0; m_bip = 0; m_pol = 0; m_cont = 0; m_ref = 0;
      m_gain = 0; m_rate = 0; m_mode = 0; m_busy = 0; m_pend = 0; m_rdy = 0;
      a_cont = 0; a_pol = 0; a_bip = 0; a_ref = 0; a_gain = 0; a_rate = 0; a_mode = 0;
      m_rem = 0; m_data = 0;
    end else begin
      fd = 0; res = 0;
      if (!ser_sel) m_cnt = 0;
      else if (ser_shift) begin
        m_sh = {m_sh[14:0], ser_bit};
        m_cnt++;
        if (m_cnt == 16) begin fd = 1; m_cnt = 0; end
      end
      if (fd) begin
        m_adce = m_sh[15]; m_bip = m_sh[13]; m_pol = m_sh[12]; m_cont = m_sh[11];
        m_ref = m_sh[10]; m_gain = int'(m_sh[9:8]); m_rate = int'(m_sh[7:5]);
        m_mode = int'(m_sh[4:2]);
      end
      go = m_adce && ((fd && m_sh[14]) || mux_start);
      if (!m_adce) begin
        m_busy = 0; m_pend = 0;
      end else if (go) begin
        m_busy = 1; m_pend = 1;
        a_cont = m_cont; a_pol = m_pol; a_bip = m_bip; a_ref = m_ref;
        a_gain = m_gain; a_rate = m_rate; a_mode = m_mode;
        m_rem = 4 * (4 << m_rate);
      end else if (m_busy && a_cont && fd && !m_cont) begin
        m_busy = 0; m_pend = 0;
      end else if (m_busy) begin
        m_rem--;
        if (m_rem == 0) begin
          m_data = fmt(int'(sample_in), a_pol, a_gain, a_bip);
          res = 1; m_pend = 0;
          if (a_cont) m_rem = 4 << a_rate;
          else m_busy = 0;
        end
      end
      if (res) m_rdy = 1;
      else if (data_rd) m_rdy = 0;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R1 cfg_word", int'(cfg_word),
          int'({m_adce, m_pend, m_bip, m_pol, m_cont, m_ref, 2'(m_gain),
                3'(m_rate), 3'(m_mode), 2'b00}));
      chk("R2 busy", int'(busy), int'(m_busy));
      chk("R13 data_ready", int'(data_ready), int'(m_rdy));
      chk("R9 adc_data", int'(adc_data), m_data);
      chk("R8 act_ref_sel", int'(act_ref_sel), int'(a_ref));
      chk("R8 act_mode", int'(act_mode), a_mode);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    ser_sel = 1'b1;
    for (int i = 15; i >= 0; i--) begin
      ser_shift = 1'b1; ser_bit = w[i];
      @(negedge clk);
    end
    ser_shift = 1'b0; ser_sel = 1'b0;
  endtask

  task automatic pulse_mux();
    @(negedge clk); mux_start = 1'b1;
    @(negedge clk); mux_start = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic one_shot(input logic [15:0] w, input int s, input string tag, input int exp);
    sample_in = 16'(s);
    send(w);
    wait_cyc(20);
    chk(tag, int'(adc_data), exp);
    pulse_rd();
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [15:0] held;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    cmp_on = 1;

    // R1: reset state
    chk("R1 reset cfg", int'(cfg_word), 0);
    chk("R1 reset ready", int'(data_ready), 0);

    // R7: continuous set while idle starts nothing
    send(mk(1, 0, 0, 0, 1, 0, 0, 0, 0));
    wait_cyc(30);
    chk("R7 idle stays", int'(busy), 0);
    chk("R1 readback", int'(cfg_word), int'(mk(1, 0, 0, 0, 1, 0, 0, 0, 0)));

    // R3/R4: single shot, rate 0 -> first result 16 clocks after start
    sample_in = 16'sd1000;
    send(mk(1, 1, 1, 0, 0, 0, 0, 0, 0));
    chk("R3 start bit set", int'(cfg_word[14]), 1);
    wait_cyc(15);
    chk("R3 not yet ready", int'(data_ready), 0);
    chk("R3 start bit held", int'(cfg_word[14]), 1);
    wait_cyc(1);
    chk("R3 ready on time", int'(data_ready), 1);
    chk("R3 start bit cleared", int'(cfg_word[14]), 0);
    chk("R4 single result", int'(adc_data), 1000);
    chk("R4 idle after one", int'(busy), 0);
    pulse_rd();
    chk("R13 read clears", int'(data_ready), 0);

    // R9 / R10 / R11: result formatting
    one_shot(mk(1, 1, 0, 0, 0, 0, 0, 0, 0), 1000, "R9 unipolar", 2000);
    one_shot(mk(1, 1, 0, 0, 0, 0, 0, 0, 0), -5, "R9 unipolar negative", 0);
    one_shot(mk(1, 1, 1, 1, 0, 0, 0, 0, 0), 1234, "R10 polarity swap", fmt(1234, 1, 0, 1));
    one_shot(mk(1, 1, 1, 1, 0, 0, 0, 0, 0), -32768, "R10 swap saturates", 32767);
    one_shot(mk(1, 1, 1, 0, 0, 0, 3, 0, 0), 5000, "R11 gain8 saturates", 32767);
    one_shot(mk(1, 1, 1, 0, 0, 0, 2, 0, 0), -300, "R11 gain4", fmt(-300, 0, 2, 1));

    // R5: continuous at rate 1 (8-clock cycles)
    sample_in = 16'sd700;
    send(mk(1, 1, 1, 0, 1, 0, 0, 1, 0));
    wait_cyc(33);
    chk("R5 first result", int'(adc_data), 700);
    sample_in = 16'sd900;
    wait_cyc(9);
    chk("R5 next result", int'(adc_data), 900);
    chk("R5 still running", int'(busy), 1);

    // R8: reconfigure without start while running
    send(mk(1, 0, 1, 0, 1, 1, 1, 0, 5));
    chk("R8 run undisturbed", int'(busy), 1);
    chk("R8 ref not taken", int'(act_ref_sel), 0);
    chk("R8 mode not taken", int'(act_mode), 0);
    wait_cyc(10);
    chk("R8 old gain kept", int'(adc_data), 900);

    // R6: clear continuous aborts and keeps data
    send(mk(1, 0, 1, 0, 0, 1, 1, 0, 5));
    chk("R6 aborted", int'(busy), 0);
    held = adc_data;
    sample_in = 16'sd100;
    wait_cyc(40);
    chk("R6 data held", int'(adc_data), int'(held));

    // R2: alternate start uses stored settings
    pulse_mux();
    chk("R2 mux start", int'(busy), 1);
    chk("R8 ref taken", int'(act_ref_sel), 1);
    chk("R8 mode taken", int'(act_mode), 5);
    wait_cyc(16);
    chk("R2 mux result", int'(adc_data), 200);
    chk("R4 mux single done", int'(busy), 0);
    pulse_rd();

    // R2: restart discards progress
    send(mk(1, 1, 1, 0, 0, 0, 0, 2, 0));
    wait_cyc(30);
    sample_in = 16'sd50;
    send(mk(1, 1, 1, 0, 0, 0, 0, 0, 0));
    wait_cyc(15);
    chk("R2 restart not ready", int'(data_ready), 0);
    wait_cyc(1);
    chk("R2 restart ready", int'(data_ready), 1);
    chk("R2 restart data", int'(adc_data), 50);
    pulse_rd();

    // R12: power-off stops continuous run
    sample_in = 16'sd60;
    send(mk(1, 1, 1, 0, 1, 0, 0, 0, 0));
    wait_cyc(30);
    send(mk(0, 1, 0, 0, 0, 0, 0, 0, 0));
    chk("R12 stopped", int'(busy), 0);
    chk("R12 start bit clear", int'(cfg_word[14]), 0);
    held = adc_data;
    wait_cyc(30);
    chk("R12 data held", int'(adc_data), int'(held));
    pulse_rd();

    // R13: result beats a simultaneous read
    send(mk(1, 1, 1, 0, 1, 0, 0, 0, 0));
    data_rd = 1'b1;
    wait_cyc(16);
    chk("R13 set wins", int'(data_ready), 1);
    wait_cyc(1);
    chk("R13 cleared after", int'(data_ready), 0);
    data_rd = 1'b0;
    send(mk(0, 0, 0, 0, 0, 0, 0, 0, 0));
    wait_cyc(10);

    done = 1;
    finish_run();
  end

endmodule